// File: doc/BRIEF.md
# Posted-Write Burst Memory Core

A single-clock on-chip memory whose accesses always move a pair of 18-bit words. A command cycle (`acc_go` high) carries the burst address, the direction (`acc_wr`) and, for a write, the first word with its two lane enables. The cycle after it carries the second word and its lane enables. A read returns the first word in the cycle after the command and the second word in the cycle after that, with `rd_valid` high in both cycles.

A finished write does not go into the storage array straight away. Its address, both words and all four lane enables are parked in a posting register. They stay there through any number of reads. On the second beat of the next write, the parked entry is written into the array and the new write takes its place in the same clock edge. A read whose address matches the parked entry builds each 9-bit lane separately: enabled lanes come from the posting register and masked lanes come from the array. Software sees plain memory semantics, and the array is never written during a read.

Control is a three-state machine:
- `ST_IDLE` accepts commands.
- `ST_WR_B1` takes the second write beat and then returns to `ST_IDLE`.
- `ST_RD_B1` drives the second read beat and then returns to `ST_IDLE`.

The transitions out of `ST_IDLE` are:
- `go_write` (`acc_go & acc_wr`) moves to `ST_WR_B1`.
- `go_read` (`acc_go & !acc_wr`) moves to `ST_RD_B1`.
- `stay_idle` keeps the machine in `ST_IDLE` when `acc_go` is low.

Top module: `pwsram_core`

## Requirements
- R1: After reset `rd_valid` is 0, the posting register is empty, and every address reads back both words as zero.
- R2: A read command accepted in `ST_IDLE` shows word 0 on `rd_data` with `rd_valid` high in the next cycle, and word 1 with `rd_valid` high in the cycle after that. `rd_valid` is 0 in every other cycle.
- R3: A write takes word 0 and its lane enables in the command cycle and word 1 and its lane enables in the following cycle. Lane enable bit 0 covers data bits 8:0 and bit 1 covers bits 17:9.
- R4: A lane whose enable is 0 during a write keeps its previous contents. Enabled lanes take the new data.
- R5: A completed write is parked in the posting register rather than the array. On the second beat of the next write, the parked entry is committed to the array and the new write is captured in the same edge.
- R6: Any number of reads between two writes leaves the parked entry unchanged, and it is still committed correctly afterwards.
- R7: A read whose address matches the parked entry returns its enabled lanes from the posting register and its masked lanes from the array. This includes a read issued in the cycle right after the write's second beat.
- R8: `acc_go` in the second cycle of an access (`ST_WR_B1` or `ST_RD_B1`) is ignored. It starts no access and produces no `rd_valid`.
- R9: A read to an address other than the parked one returns the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_go | input | 1 | Command strobe, honoured only in `ST_IDLE` |
| acc_wr | input | 1 | 1 = write burst, 0 = read burst |
| acc_addr | input | ADDR_W (6) | Burst address |
| wr_data | input | WORD_W (18) | Write word: word 0 in the command cycle, word 1 in the next cycle |
| wr_lane_en | input | LANES (2) | Lane enables for the word on `wr_data` |
| rd_data | output | WORD_W (18) | Read word: word 0, then word 1 |
| rd_valid | output | 1 | High while `rd_data` carries a read word |

## Verification
The assertions assume that commands arrive only as whole two-cycle accesses. They also assume that reset is held low for several clocks before the first command, so that no `$past` term reaches back before reset. The bench drives every access through tasks that always spend the second beat before issuing a new command. In a few places it deliberately raises `acc_go` during that second beat, and those strobes must be ignored. Random traffic is confined to eight addresses so that same-address reads and writes, masked lanes and repeated commits of the parked entry happen often. A behavioural memory array predicts every output cycle.

// File: rtl/pwsram_pkg.sv
package pwsram_pkg;
    localparam int BEATS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WR_B1 = 2'd1,
        ST_RD_B1 = 2'd2
    } acc_state_e;
endpackage

// File: rtl/pwsram_ctrl.sv
module pwsram_ctrl
    import pwsram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_go,
    input  logic       acc_wr,
    output acc_state_e state,
    output logic       wr_issue,
    output logic       rd_issue,
    output logic       cap_en,
    output logic       rd_valid
);
    acc_state_e state_nx;

    // Commands are decoded only in the idle state.
    always_comb begin
        wr_issue = (state == ST_IDLE) && acc_go && acc_wr;
        rd_issue = (state == ST_IDLE) && acc_go && !acc_wr;
        cap_en   = (state == ST_WR_B1);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_issue)      state_nx = ST_WR_B1;
                else if (rd_issue) state_nx = ST_RD_B1;
            end
            ST_WR_B1: state_nx = ST_IDLE;
            ST_RD_B1: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register: valid for both read beats.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_issue || (state == ST_RD_B1);
    end

    AST_BEAT1_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE)); // R8
    AST_RD_SECOND_BEAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_B1) |-> rd_valid); // R2
    AST_WRITE_HAS_BEAT1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> cap_en); // R3
endmodule

// File: rtl/pwsram_array.sv
module pwsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int NL     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NL*LANE_W-1:0] rd_data,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NL*LANE_W-1:0] wr_data,
    input  logic [NL-1:0]        wr_mask
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && wr_mask[l]) begin
                mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/pwsram_hold.sv
module pwsram_hold #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int NL     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [ADDR_W-1:0]    cap_addr,
    input  logic [NL*LANE_W-1:0] cap_data,
    input  logic [NL-1:0]        cap_mask,
    output logic                 commit_en,
    output logic [ADDR_W-1:0]    commit_addr,
    output logic [NL*LANE_W-1:0] commit_data,
    output logic [NL-1:0]        commit_mask,
    input  logic [ADDR_W-1:0]    look_addr,
    input  logic [NL*LANE_W-1:0] arr_data,
    output logic [NL*LANE_W-1:0] fwd_data
);
    logic                 hold_vld;
    logic [ADDR_W-1:0]    hold_addr;
    logic [NL*LANE_W-1:0] hold_data;
    logic [NL-1:0]        hold_mask;
    logic                 hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            hold_mask <= '0;
        end else if (cap_en) begin
            hold_vld  <= 1'b1;
            hold_addr <= cap_addr;
            hold_data <= cap_data;
            hold_mask <= cap_mask;
        end
    end

    // The old entry leaves on the same edge that the new one arrives.
    assign commit_en   = cap_en && hold_vld;
    assign commit_addr = hold_addr;
    assign commit_data = hold_data;
    assign commit_mask = hold_mask;

    assign hit = hold_vld && (hold_addr == look_addr);

    for (genvar l = 0; l < NL; l++) begin : g_fwd
        assign fwd_data[l*LANE_W +: LANE_W] = (hit && hold_mask[l])
            ? hold_data[l*LANE_W +: LANE_W]
            : arr_data[l*LANE_W +: LANE_W];
    end

    AST_HOLD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (hold_vld && hold_addr == $past(cap_addr))); // R5
    AST_HOLD_KEPT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(hold_addr) && $stable(hold_data) && $stable(hold_mask))); // R6
    AST_HOLD_STAYS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hold_vld |=> hold_vld); // R5
endmodule

// File: rtl/pwsram_core.sv
module pwsram_core
    import pwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANE_W = WORD_W / LANES;
    localparam int NL     = LANES * BEATS;
    localparam int BW     = NL * LANE_W;

    acc_state_e        state;
    logic              wr_issue, rd_issue, cap_en;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] stage_d;
    logic [LANES-1:0]  stage_m;
    logic [WORD_W-1:0] rd_buf;
    logic [WORD_W-1:0] rd_q;

    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [BW-1:0]     commit_data, arr_data, fwd_data;
    logic [NL-1:0]     commit_mask;

    pwsram_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_go   (acc_go),
        .acc_wr   (acc_wr),
        .state    (state),
        .wr_issue (wr_issue),
        .rd_issue (rd_issue),
        .cap_en   (cap_en),
        .rd_valid (rd_valid)
    );

    // Word 0 of a write waits here for word 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            stage_d <= '0;
            stage_m <= '0;
        end else if (wr_issue) begin
            addr_q  <= acc_addr;
            stage_d <= wr_data;
            stage_m <= wr_lane_en;
        end
    end

    pwsram_hold #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NL(NL)) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .cap_addr    (addr_q),
        .cap_data    ({wr_data, stage_d}),
        .cap_mask    ({wr_lane_en, stage_m}),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_mask (commit_mask),
        .look_addr   (acc_addr),
        .arr_data    (arr_data),
        .fwd_data    (fwd_data)
    );

    pwsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NL(NL)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (acc_addr),
        .rd_data (arr_data),
        .we      (commit_en),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .wr_mask (commit_mask)
    );

    // Read path: word 0 goes straight out, word 1 waits one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_buf <= '0;
            rd_q   <= '0;
        end else if (rd_issue) begin
            rd_q   <= fwd_data[WORD_W-1:0];
            rd_buf <= fwd_data[2*WORD_W-1:WORD_W];
        end else if (state == ST_RD_B1) begin
            rd_q   <= rd_buf;
        end
    end

    assign rd_data = rd_q;

    AST_COMMIT_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (state == ST_WR_B1)); // R5
    AST_NO_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_B1) |=> !rd_valid); // R8
endmodule

// File: tb/test_pwsram_core.sv
module test_pwsram_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_go = 1'b0;
    logic        acc_wr = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [17:0] wr_data = '0;
    logic [1:0]  wr_lane_en = '0;
    logic [17:0] rd_data;
    logic        rd_valid;

    always #10 clk = ~clk;

    pwsram_core i_pwsram_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_go     (acc_go),
        .acc_wr     (acc_wr),
        .acc_addr   (acc_addr),
        .wr_data    (wr_data),
        .wr_lane_en (wr_lane_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    logic [17:0] ref_mem [64][2];
    logic [17:0] exp_d [int];
    int    edge_n = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    mon_on = 1'b0;
    string cur_req = "R1";

    always @(posedge clk) edge_n++;

    // Per-cycle comparison against the reference memory model.
    always @(negedge clk) begin
        if (mon_on) begin
            n_chk++;
            if (exp_d.exists(edge_n)) begin
                if (rd_valid !== 1'b1 || rd_data !== exp_d[edge_n]) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: valid=%b data=%h expected valid=1 data=%h",
                             cur_req, edge_n, rd_valid, rd_data, exp_d[edge_n]);
                end
            end else if (rd_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL %s cycle %0d: valid=%b expected valid=0",
                         cur_req, edge_n, rd_valid);
            end
        end
    end

    function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] nw, logic [1:0] m);
        merge = old;
        if (m[0]) merge[8:0]  = nw[8:0];
        if (m[1]) merge[17:9] = nw[17:9];
    endfunction

    task automatic do_write(input logic [5:0] a, input logic [17:0] d0, input logic [1:0] m0,
                            input logic [17:0] d1, input logic [1:0] m1, input bit ghost);
        @(negedge clk);
        acc_go = 1'b1; acc_wr = 1'b1; acc_addr = a; wr_data = d0; wr_lane_en = m0;
        @(negedge clk);
        wr_data = d1; wr_lane_en = m1;
        if (ghost) begin
            acc_go = 1'b1; acc_wr = 1'b0; acc_addr = a ^ 6'h2A;   // R8: must be ignored
        end else begin
            acc_go = 1'b0;
        end
        ref_mem[a][0] = merge(ref_mem[a][0], d0, m0);
        ref_mem[a][1] = merge(ref_mem[a][1], d1, m1);
    endtask

    task automatic do_read(input logic [5:0] a, input bit ghost);
        @(negedge clk);
        acc_go = 1'b1; acc_wr = 1'b0; acc_addr = a;
        exp_d[edge_n + 1] = ref_mem[a][0];
        exp_d[edge_n + 2] = ref_mem[a][1];
        @(negedge clk);
        if (ghost) begin
            acc_go = 1'b1; acc_wr = 1'b1; acc_addr = a ^ 6'h15;   // R8: must be ignored
        end else begin
            acc_go = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_go = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        for (int a = 0; a < 64; a++) begin
            ref_mem[a][0] = '0;
            ref_mem[a][1] = '0;
        end
        repeat (4) @(negedge clk);
        n_chk++;
        if (rd_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: valid=%b expected 0", rd_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R1: every address reads zero after reset.
        cur_req = "R1";
        for (int a = 0; a < 64; a++) do_read(a[5:0], 1'b0);
        idle(2);

        // R2, R3: full write, commit by another write, then read back.
        cur_req = "R2/R3";
        do_write(6'd5, 18'h1A5A5, 2'b11, 18'h25A5A, 2'b11, 1'b0);
        do_write(6'd6, 18'h00F0F, 2'b11, 18'h3F0F0, 2'b11, 1'b0);
        do_read(6'd5, 1'b0);
        do_read(6'd6, 1'b0);
        idle(3);

        // R7: read in the cycle right after the write's second beat.
        cur_req = "R7";
        do_write(6'd10, 18'h12345, 2'b11, 18'h2ABCD, 2'b11, 1'b0);
        do_read(6'd10, 1'b0);

        // R6, R9: several reads while an entry is parked, then commit.
        cur_req = "R6/R9";
        do_write(6'd11, 18'h33333, 2'b11, 18'h04444, 2'b11, 1'b0);
        do_read(6'd11, 1'b0);
        do_read(6'd5, 1'b0);
        do_read(6'd11, 1'b0);
        do_read(6'd10, 1'b0);
        do_read(6'd11, 1'b0);
        cur_req = "R5";
        do_write(6'd12, 18'h15555, 2'b11, 18'h0AAAA, 2'b11, 1'b0);
        do_read(6'd11, 1'b0);
        do_read(6'd12, 1'b0);
        idle(2);

        // R4: lane masks on committed data.
        cur_req = "R4";
        do_write(6'd9, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11, 1'b0);
        do_write(6'd9, 18'h00000, 2'b01, 18'h00000, 2'b10, 1'b0);
        do_write(6'd20, 18'h11111, 2'b00, 18'h22222, 2'b00, 1'b0);
        do_read(6'd9, 1'b0);
        do_read(6'd20, 1'b0);

        // R7: partial write parked over an older full write, read merges lanes.
        cur_req = "R7";
        do_write(6'd14, 18'h2DEAD, 2'b11, 18'h1BEEF, 2'b11, 1'b0);
        do_write(6'd14, 18'h0C0DE, 2'b10, 18'h3CAFE, 2'b01, 1'b0);
        do_read(6'd14, 1'b0);
        do_read(6'd14, 1'b0);

        // R8: strobes during the second beat are ignored.
        cur_req = "R8";
        do_write(6'd30, 18'h13579, 2'b11, 18'h2468A, 2'b11, 1'b1);
        idle(1);
        do_read(6'd30, 1'b1);
        idle(1);
        do_read(6'd30 ^ 6'h15, 1'b0);
        do_read(6'd30 ^ 6'h2A, 1'b0);
        idle(2);

        // R4/R5/R7: mixed traffic on a small address window.
        cur_req = "R4/R5/R7";
        for (int i = 0; i < 600; i++) begin
            logic [5:0] a;
            a = 6'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 0)
                do_write(a, 18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom),
                         ($urandom_range(0, 3) == 0));
            else
                do_read(a, ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(4);
        mon_on = 1'b0;
        summary();
    end
endmodule